// File: doc/BRIEF.md
# Locked Configuration Port with GPIO Direction Bank

This block is the configuration front end of a legacy multi-function I/O device, seen from a byte-wide I/O bus. It has two bus addresses: an index port, which selects a configuration register, and a data port, which reads or writes the selected register. Out of reset the port is locked. While it is locked, only a fixed four-byte key written to the index port has any effect. After the key is accepted, the host can select a logical device, read the identification registers, and program the GPIO function's base address and per-group direction and simple-I/O switches. Writing the exit command locks the port again.

The direction and simple-I/O registers drive output vectors straight into a GPIO bank. Bit `b` of group `g` controls line `8*g+b`. Reads have no side effects, and the read data is a combinational function of the current address and the block state.

Top module: `cfg_port_top`

## Requirements
- R1: After reset the port is locked. `gpio_oe` and `gpio_simple` are all zero, and the GPIO base address holds `BASE_DEFAULT`.
- R2: Writing the bytes 0x87, 0x01, 0x55, 0x55 to the index port (0x2E), in that order and with any number of idle cycles between them, sets `cfg_unlocked` one clock after the last byte.
- R3: While the port is locked, an index-port byte that does not match the next expected key byte restarts the key. If that byte is 0x87, it counts as the first key byte.
- R4: While the port is locked, the data port (0x2F) reads 0xFF, and data-port writes change no register and no output. Index-port writes do not load the index.
- R5: While the port is unlocked, writing 0x02 to the data port with index 0x02 locks the port. Any other value written to index 0x02 has no effect.
- R6: Register 0x07 holds the logical-device number. It can be read and written. Logical device 0x07 selects the GPIO bank.
- R7: Registers 0x20 and 0x21 return the high and low bytes of `CHIP_ID`. Register 0x22 returns `CHIP_REV` in bits 3:0 and zero in bits 7:4. Writes to these three registers are ignored.
- R8: In the GPIO bank, register 0x62 holds the high byte and register 0x63 the low byte of the 16-bit base address. Both registers can be read and written.
- R9: In the GPIO bank, register 0xC8+g (g < `NUM_GROUPS`) can be read and written. Its bit b drives `gpio_oe[8*g+b]`, and a 1 makes that line an output.
- R10: In the GPIO bank, register 0xC0+g exists only for g < `SIMPLE_GROUPS` and drives `gpio_simple[8*g+b]`. Registers 0xC0+g for g >= `SIMPLE_GROUPS` read 0x00 and ignore writes.
- R11: Unimplemented registers read 0x00 and ignore writes. This includes the GPIO-bank registers while another logical device is selected.
- R12: While the port is unlocked, the index port reads back the current index. While it is locked, the index port reads 0xFF. Any other bus address reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W (16) | Bus I/O address |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` |
| cfg_unlocked | output | 1 | High while configuration access is open |
| gpio_oe | output | NUM_GROUPS*8 (64) | Line direction, 1 = output |
| gpio_simple | output | SIMPLE_GROUPS*8 (40) | Simple-I/O enable per line |

## Verification
The assertions take for granted that `io_wr` is a single-cycle byte strobe with a stable address and data, and that a reset held for more than one clock starts every run. They also assume that only the data-port path changes the GPIO-bank registers. The stimulus drives every bus transaction from tasks at the falling edge and holds reset for several cycles. It uses key sequences with and without mismatches, including a repeated 0x87 and a wrong fourth byte. It writes to the read-only registers, to the gaps in the map and to the data port while locked, so that each case checks an output that could have moved.

// File: rtl/cfg_pkg.sv
// Shared constants for the configuration port: unlock key, register
// indices, bank numbers and the key-matcher state type.
package cfg_pkg;
    localparam logic [7:0] KEY_B0      = 8'h87;
    localparam logic [7:0] KEY_B1      = 8'h01;
    localparam logic [7:0] KEY_B2      = 8'h55;
    localparam logic [7:0] KEY_B3      = 8'h55;
    localparam logic [7:0] REG_EXIT    = 8'h02;
    localparam logic [7:0] EXIT_CMD    = 8'h02;
    localparam logic [7:0] REG_LDN     = 8'h07;
    localparam logic [7:0] REG_ID_HI   = 8'h20;
    localparam logic [7:0] REG_ID_LO   = 8'h21;
    localparam logic [7:0] REG_REV     = 8'h22;
    localparam logic [7:0] REG_BASE_HI = 8'h62;
    localparam logic [7:0] REG_BASE_LO = 8'h63;
    localparam logic [7:0] REG_SIMPLE0 = 8'hC0;
    localparam logic [7:0] REG_OE0     = 8'hC8;
    localparam logic [7:0] GPIO_LDN    = 8'h07;

    typedef enum logic [2:0] {
        KS_WAIT0, KS_WAIT1, KS_WAIT2, KS_WAIT3, KS_OPEN
    } key_state_e;

    // Key byte expected while the matcher is in state s.
    function automatic logic [7:0] key_expect(key_state_e s);
        case (s)
            KS_WAIT0: return KEY_B0;
            KS_WAIT1: return KEY_B1;
            KS_WAIT2: return KEY_B2;
            default:  return KEY_B3;
        endcase
    endfunction
endpackage

// File: rtl/cfg_unlock.sv
// Key matcher that gates configuration access.
// Walks through the four key bytes as they are written to the index port,
// opens after the last one and closes again on the exit request.
// Assumes: key_wr is a single-cycle strobe; exit_req is only raised while open.
module cfg_unlock
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       exit_req,
    output logic       unlocked
);
    key_state_e state_q, state_d;

    // Next-state selection for the key walk and the exit.
    always_comb begin
        state_d = state_q;
        if (state_q == KS_OPEN) begin
            if (exit_req) state_d = KS_WAIT0;
        end else if (key_wr) begin
            if (key_byte == key_expect(state_q))
                state_d = key_state_e'(state_q + 3'd1);
            else if (key_byte == KEY_B0)
                state_d = KS_WAIT1;
            else
                state_d = KS_WAIT0;
        end
    end

    // State register, locked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_WAIT0;
        else        state_q <= state_d;
    end

    assign unlocked = (state_q == KS_OPEN);

    // R2
    open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_wr && key_byte == KEY_B3));
    // R5
    close_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlocked) |-> $past(exit_req));
endmodule

// File: rtl/cfg_regfile.sv
// Banked configuration register file.
// Holds the logical-device select, fixed identification values, the GPIO
// base address and the per-group direction and simple-I/O enables.
// Assumes: wr_en is only raised for data-port writes while unlocked.
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter int          NUM_GROUPS    = 8,
    parameter int          SIMPLE_GROUPS = 5,
    parameter logic [15:0] CHIP_ID       = 16'h8728,
    parameter logic [3:0]  CHIP_REV      = 4'h3,
    parameter logic [15:0] BASE_DEFAULT  = 16'h0A00,
    localparam int         OE_W          = NUM_GROUPS * 8,
    localparam int         SIMPLE_W      = SIMPLE_GROUPS * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          idx,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic [OE_W-1:0]     gpio_oe,
    output logic [SIMPLE_W-1:0] gpio_simple
);
    logic [7:0]  ldn_q;
    logic [15:0] base_q;
    logic        gpio_sel;

    assign gpio_sel = (ldn_q == GPIO_LDN);

    // Logical-device select register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ldn_q <= 8'h00;
        else if (wr_en && idx == REG_LDN)    ldn_q <= wdata;
    end

    // GPIO base address, written one byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= BASE_DEFAULT;
        else if (wr_en && gpio_sel) begin
            if (idx == REG_BASE_HI) base_q[15:8] <= wdata;
            if (idx == REG_BASE_LO) base_q[7:0]  <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_oe
        logic [7:0] grp_q;
        // Direction byte for group g.
        always_ff @(posedge clk) begin
            if (!rst_n) grp_q <= 8'h00;
            else if (wr_en && gpio_sel && idx == 8'(REG_OE0 + g)) grp_q <= wdata;
        end
        assign gpio_oe[8*g +: 8] = grp_q;
    end

    for (genvar g = 0; g < SIMPLE_GROUPS; g++) begin : g_simple
        logic [7:0] grp_q;
        // Simple-I/O enable byte for group g.
        always_ff @(posedge clk) begin
            if (!rst_n) grp_q <= 8'h00;
            else if (wr_en && gpio_sel && idx == 8'(REG_SIMPLE0 + g)) grp_q <= wdata;
        end
        assign gpio_simple[8*g +: 8] = grp_q;
    end

    // Read multiplexer; anything not matched reads zero.
    always_comb begin
        rdata = 8'h00;
        case (idx)
            REG_LDN:   rdata = ldn_q;
            REG_ID_HI: rdata = CHIP_ID[15:8];
            REG_ID_LO: rdata = CHIP_ID[7:0];
            REG_REV:   rdata = {4'h0, CHIP_REV};
            default: begin
                if (gpio_sel) begin
                    if (idx == REG_BASE_HI) rdata = base_q[15:8];
                    if (idx == REG_BASE_LO) rdata = base_q[7:0];
                    for (int g = 0; g < NUM_GROUPS; g++)
                        if (idx == 8'(REG_OE0 + g)) rdata = gpio_oe[8*g +: 8];
                    for (int g = 0; g < SIMPLE_GROUPS; g++)
                        if (idx == 8'(REG_SIMPLE0 + g)) rdata = gpio_simple[8*g +: 8];
                end
            end
        endcase
    end

    // R6
    ldn_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ldn_q != $past(ldn_q)) |-> $past(wr_en && idx == REG_LDN));
    // R9
    oe_needs_gpio_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_oe != $past(gpio_oe)) |-> $past(wr_en && ldn_q == GPIO_LDN));
endmodule

// File: rtl/cfg_port_top.sv
// Configuration port top: decodes the index and data addresses, holds the
// index register, detects the exit command and steers reads.
// Assumes: one bus write per cycle, address and data valid with io_wr.
module cfg_port_top
    import cfg_pkg::*;
#(
    parameter int          ADDR_W        = 16,
    parameter logic [15:0] INDEX_ADDR    = 16'h002E,
    parameter logic [15:0] DATA_ADDR     = 16'h002F,
    parameter int          NUM_GROUPS    = 8,
    parameter int          SIMPLE_GROUPS = 5,
    parameter logic [15:0] CHIP_ID       = 16'h8728,
    parameter logic [3:0]  CHIP_REV      = 4'h3,
    parameter logic [15:0] BASE_DEFAULT  = 16'h0A00,
    localparam int         OE_W          = NUM_GROUPS * 8,
    localparam int         SIMPLE_W      = SIMPLE_GROUPS * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic                io_wr,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    output logic                cfg_unlocked,
    output logic [OE_W-1:0]     gpio_oe,
    output logic [SIMPLE_W-1:0] gpio_simple
);
    logic       at_index, at_data;
    logic       exit_req, reg_wr;
    logic [7:0] idx_q, reg_rdata;

    assign at_index = (io_addr == ADDR_W'(INDEX_ADDR));
    assign at_data  = (io_addr == ADDR_W'(DATA_ADDR));
    assign exit_req = io_wr && at_data && cfg_unlocked &&
                      idx_q == REG_EXIT && io_wdata == EXIT_CMD;
    assign reg_wr   = io_wr && at_data && cfg_unlocked && !exit_req;

    // Index register: loaded only while open, cleared when closing.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   idx_q <= 8'h00;
        else if (io_wr && at_index && cfg_unlocked)   idx_q <= io_wdata;
        else if (exit_req)                            idx_q <= 8'h00;
    end

    cfg_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (io_wr && at_index),
        .key_byte (io_wdata),
        .exit_req (exit_req),
        .unlocked (cfg_unlocked)
    );

    cfg_regfile #(
        .NUM_GROUPS    (NUM_GROUPS),
        .SIMPLE_GROUPS (SIMPLE_GROUPS),
        .CHIP_ID       (CHIP_ID),
        .CHIP_REV      (CHIP_REV),
        .BASE_DEFAULT  (BASE_DEFAULT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .idx         (idx_q),
        .wdata       (io_wdata),
        .rdata       (reg_rdata),
        .gpio_oe     (gpio_oe),
        .gpio_simple (gpio_simple)
    );

    // Read steering by bus address and lock state.
    always_comb begin
        if (at_index)     io_rdata = cfg_unlocked ? idx_q : 8'hFF;
        else if (at_data) io_rdata = cfg_unlocked ? reg_rdata : 8'hFF;
        else              io_rdata = 8'hFF;
    end

    // R4
    locked_keeps_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |=> $stable(gpio_oe));
    // R4
    locked_keeps_simple_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |=> $stable(gpio_simple));
endmodule

// File: tb/cfg_port_top_test.sv
module cfg_port_top_test;
    localparam int IDX = 16'h2E, DAT = 16'h2F;
    logic clk = 0, rst_n = 0, io_wr = 0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0] io_wdata = 8'h0, io_rdata;
    logic cfg_unlocked;
    logic [63:0] gpio_oe;
    logic [39:0] gpio_simple;
    int checks = 0, fails = 0;
    bit running = 0;

    // reference model state
    bit m_open = 0;
    int m_pos = 0;
    int m_idx = 0, m_ldn = 0, m_base = 16'h0A00;
    int m_oe[8];
    int m_simple[5];
    byte unsigned key[4] = '{8'h87, 8'h01, 8'h55, 8'h55};

    always #5 clk = ~clk;

    cfg_port_top uut (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(cfg_unlocked),
        .gpio_oe(gpio_oe), .gpio_simple(gpio_simple));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void m_write(int a, int d);
        if (a == IDX) begin
            if (m_open) m_idx = d;
            else if (d == key[m_pos]) begin
                m_pos++;
                if (m_pos == 4) begin m_open = 1; m_pos = 0; end
            end else m_pos = (d == 8'h87) ? 1 : 0;
        end else if (a == DAT && m_open) begin
            if (m_idx == 2 && d == 2) begin m_open = 0; m_idx = 0; end
            else if (m_idx == 7) m_ldn = d;
            else if (m_ldn == 7) begin
                if (m_idx == 8'h62) m_base = (m_base & 8'hFF) | (d << 8);
                if (m_idx == 8'h63) m_base = (m_base & 16'hFF00) | d;
                if (m_idx >= 8'hC8 && m_idx < 8'hD0) m_oe[m_idx - 8'hC8] = d;
                if (m_idx >= 8'hC0 && m_idx < 8'hC5) m_simple[m_idx - 8'hC0] = d;
            end
        end
    endfunction

    function automatic int m_read(int a);
        if (a == IDX) return m_open ? m_idx : 8'hFF;
        if (a != DAT || !m_open) return 8'hFF;
        case (m_idx)
            8'h07: return m_ldn;
            8'h20: return 8'h87;
            8'h21: return 8'h28;
            8'h22: return 8'h03;
            default: begin
                if (m_ldn != 7) return 0;
                if (m_idx == 8'h62) return m_base >> 8;
                if (m_idx == 8'h63) return m_base & 8'hFF;
                if (m_idx >= 8'hC8 && m_idx < 8'hD0) return m_oe[m_idx - 8'hC8];
                if (m_idx >= 8'hC0 && m_idx < 8'hC5) return m_simple[m_idx - 8'hC0];
                return 0;
            end
        endcase
    endfunction

    // per-cycle comparison of the outputs against the model
    always @(negedge clk) if (running) begin
        logic [63:0] eo;
        logic [39:0] es;
        for (int g = 0; g < 8; g++) eo[8*g +: 8] = 8'(m_oe[g]);
        for (int g = 0; g < 5; g++) es[8*g +: 8] = 8'(m_simple[g]);
        check("R2 unlocked", int'(cfg_unlocked), int'(m_open));
        if (gpio_oe != eo) check("R9 gpio_oe", 0, 1); else check("R9 gpio_oe", 0, 0);
        if (gpio_simple != es) check("R10 gpio_simple", 0, 1); else check("R10 gpio_simple", 0, 0);
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1;
        @(posedge clk);
        #1 m_write(a, d);
        io_wr = 0;
    endtask

    task automatic rd(string req, int a);
        @(negedge clk);
        io_addr = 16'(a);
        #1 check(req, int'(io_rdata), m_read(a));
    endtask

    task automatic reg_wr(int i, int d); wr(IDX, i); wr(DAT, d); endtask
    task automatic reg_rd(string req, int i); wr(IDX, i); rd(req, DAT); endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        foreach (m_oe[i]) m_oe[i] = 0;
        foreach (m_simple[i]) m_simple[i] = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        running = 1;
        // R1 reset state
        rd("R1 data locked", DAT);
        rd("R12 index locked", IDX);
        check("R1 oe reset", int'(gpio_oe == 0), 1);
        // R4 locked writes ignored
        wr(IDX, 8'hC8); wr(DAT, 8'hFF);
        rd("R4 data locked", DAT);
        // R3 wrong fourth byte keeps lock
        wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h12);
        check("R3 wrong byte", int'(cfg_unlocked), 0);
        // R3 repeated first byte restarts at position one
        wr(IDX, 8'h87); wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55);
        @(negedge clk); @(negedge clk);
        wr(IDX, 8'h55);
        check("R3 restart unlock", int'(cfg_unlocked), 1);
        // R7 identification and read-only
        reg_rd("R7 id hi", 8'h20); reg_rd("R7 id lo", 8'h21); reg_rd("R7 rev", 8'h22);
        reg_wr(8'h20, 8'h00); reg_rd("R7 id ro", 8'h20);
        // R11 GPIO bank hidden with LDN 0
        reg_rd("R11 bank hidden", 8'h62);
        reg_wr(8'hC8, 8'h33);
        // R6 select GPIO device
        reg_wr(8'h07, 8'h07); reg_rd("R6 ldn", 8'h07);
        // R8 base address
        reg_rd("R8 base hi default", 8'h62); reg_rd("R8 base lo default", 8'h63);
        reg_wr(8'h62, 8'h12); reg_wr(8'h63, 8'h34);
        reg_rd("R8 base hi", 8'h62); reg_rd("R8 base lo", 8'h63);
        // R9 direction groups
        reg_wr(8'hC8, 8'hA5); reg_wr(8'hCF, 8'h81); reg_wr(8'hCB, 8'h0F);
        reg_rd("R9 oe g0", 8'hC8); reg_rd("R9 oe g7", 8'hCF);
        check("R9 oe line 63", int'(gpio_oe[63]), 1);
        check("R9 oe line 1", int'(gpio_oe[1]), 0);
        // R10 simple-I/O groups and the gap above them
        reg_wr(8'hC0, 8'hFF); reg_wr(8'hC4, 8'h0F); reg_wr(8'hC5, 8'h77);
        reg_rd("R10 simple g4", 8'hC4); reg_rd("R10 simple gap", 8'hC5);
        check("R10 simple line 35", int'(gpio_simple[35]), 1);
        // R11 unimplemented register
        reg_wr(8'h30, 8'h5A); reg_rd("R11 unimpl", 8'h30);
        // R11 other device hides bank and ignores writes
        reg_wr(8'h07, 8'h03); reg_wr(8'hC8, 8'h00); reg_rd("R11 other ldn", 8'hC8);
        reg_wr(8'h07, 8'h07); reg_rd("R11 oe kept", 8'hC8);
        // R12 index readback and other addresses
        wr(IDX, 8'h5C); rd("R12 index read", IDX); rd("R12 other addr", 16'h0080);
        // R5 exit needs exact value
        reg_wr(8'h02, 8'h01);
        check("R5 wrong exit", int'(cfg_unlocked), 1);
        reg_wr(8'h02, 8'h02);
        check("R5 exit", int'(cfg_unlocked), 0);
        wr(DAT, 8'h00);
        rd("R4 locked after exit", DAT);
        // R2 exact key reopens
        wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h55);
        check("R2 before last byte", int'(cfg_unlocked), 0);
        wr(IDX, 8'h55);
        check("R2 open", int'(cfg_unlocked), 1);
        reg_rd("R9 oe survives lock", 8'hC8);
        @(negedge clk);
        running = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule